// File: doc/BRIEF.md
# Parking Free-Slot Count Display

This block watches a garage of 31 parking spaces and shows how many spaces a driver can still take. Each space has a sensor bit that reads 1 while a car stands on it. A separate input gives how many spaces are held back for reservations. The block counts the occupied spaces and takes both that count and the reserved count away from the full capacity. It signals when nothing is left, so that the entrance barrier can stay closed.

The remaining count goes to two decimal digits, tens and units. These digits drive two common-anode seven-segment digits whose segment lines are low when lit. The block has no clock. Every output follows the two inputs through combinational logic only. When the reserved and occupied spaces together reach or pass the capacity, the block raises the full flag and the display reads "00". It never shows a negative value.

Top module: `park_free_display`

## Requirements
- R1: `occ_cnt` equals the number of ones in `slot_occ`. For example, slot_occ = 31'b100_1011_1110_1111_1000_1111_1010_1110 gives occ_cnt = 21.
- R2: When 31 − occ_cnt − resv_cnt is positive, `free_cnt` equals that difference. `resv_cnt` is read as unsigned, 0 to 31.
- R3: `full` is 1 exactly when 31 − occ_cnt − resv_cnt is zero or negative. This includes the over-reserved case, where occ_cnt + resv_cnt > 31.
- R4: While `full` is 1, `free_cnt`, `tens_bcd` and `units_bcd` are all 0.
- R5: `tens_bcd` and `units_bcd` are the decimal digits of `free_cnt`, so that tens_bcd×10 + units_bcd = free_cnt and units_bcd ≤ 9. For example, 13 gives tens 4'b0001 and units 4'b0011.
- R6: Both segment outputs are active low and ordered {g,f,e,d,c,b,a} from bit 6 down to bit 0. The digits 0 to 9 give 7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78, 7'h00 and 7'h10. A code from 10 to 15 gives 7'h7F, which is blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slot_occ | input | 31 | Occupancy sensor bits, one per space, 1 = occupied |
| resv_cnt | input | 5 | Number of reserved spaces, unsigned |
| occ_cnt | output | 5 | Number of occupied spaces |
| free_cnt | output | 5 | Free spaces, clamped to 0 when full |
| full | output | 1 | High when no space is left; closes the barrier |
| tens_bcd | output | 4 | BCD tens digit of free_cnt |
| units_bcd | output | 4 | BCD units digit of free_cnt |
| seg_tens_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} for the tens digit |
| seg_units_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} for the units digit |

## Verification
The checker re-tests the following after every input change:
- the count-versus-sensor relation;
- the full condition written as a sum test against capacity;
- the forcing of the display to zero when full;
- the digit recombination.

These hold for any input values. The segment patterns for each digit are not checked there. Only the bench's sweep can show them. It also covers the exact boundary where occupied plus reserved equals 31, and the fixed example vectors. The sweep walks every pairing of occupied count and reserved count, with the occupied bits placed at shifting positions.

// File: rtl/park_pkg.sv
package park_pkg;
    localparam int unsigned SEG_W = 7;
    typedef logic [SEG_W-1:0] seg_t;
    localparam seg_t SEG_BLANK = 7'h7F;
endpackage

// File: rtl/park_popcount.sv
module park_popcount #(
    parameter int unsigned WIDTH = 31,
    parameter int unsigned CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] bits_in,
    output logic [CNT_W-1:0] ones_out
);
    always_comb begin
        ones_out = '0;
        for (int i = 0; i < WIDTH; i++) begin
            ones_out = ones_out + CNT_W'(bits_in[i]);
        end
    end
endmodule

// File: rtl/park_free_calc.sv
module park_free_calc #(
    parameter int unsigned CAPACITY = 31,
    parameter int unsigned CNT_W    = 5,
    parameter int unsigned RS_W     = 5
) (
    input  logic [CNT_W-1:0] occ_in,
    input  logic [RS_W-1:0]  resv_in,
    output logic [CNT_W-1:0] free_out,
    output logic             full_out
);
    localparam int unsigned DIFF_W = ((CNT_W > RS_W) ? CNT_W : RS_W) + 2;

    logic signed [DIFF_W-1:0] diff;

    always_comb begin
        diff     = DIFF_W'(CAPACITY) - DIFF_W'(occ_in) - DIFF_W'(resv_in);
        full_out = (diff <= 0);
        free_out = full_out ? '0 : diff[CNT_W-1:0];
    end
endmodule

// File: rtl/park_bcd_split.sv
module park_bcd_split #(
    parameter int unsigned CNT_W = 5
) (
    input  logic [CNT_W-1:0] bin_in,
    output logic [3:0]       tens_out,
    output logic [3:0]       units_out
);
    always_comb begin
        tens_out  = 4'(bin_in / CNT_W'(10));
        units_out = 4'(bin_in % CNT_W'(10));
    end
endmodule

// File: rtl/park_seg7.sv
module park_seg7
    import park_pkg::*;
(
    input  logic [3:0] code_in,
    output seg_t       seg_n_out
);
    always_comb begin
        unique case (code_in)
            4'd0:    seg_n_out = 7'h40;
            4'd1:    seg_n_out = 7'h79;
            4'd2:    seg_n_out = 7'h24;
            4'd3:    seg_n_out = 7'h30;
            4'd4:    seg_n_out = 7'h19;
            4'd5:    seg_n_out = 7'h12;
            4'd6:    seg_n_out = 7'h02;
            4'd7:    seg_n_out = 7'h78;
            4'd8:    seg_n_out = 7'h00;
            4'd9:    seg_n_out = 7'h10;
            default: seg_n_out = SEG_BLANK;
        endcase
    end
endmodule

// File: rtl/park_free_display.sv
module park_free_display
    import park_pkg::*;
#(
    parameter int unsigned SLOTS = 31,
    parameter int unsigned RS_W  = 5,
    parameter int unsigned CNT_W = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0] slot_occ,
    input  logic [RS_W-1:0]  resv_cnt,
    output logic [CNT_W-1:0] occ_cnt,
    output logic [CNT_W-1:0] free_cnt,
    output logic             full,
    output logic [3:0]       tens_bcd,
    output logic [3:0]       units_bcd,
    output logic [6:0]       seg_tens_n,
    output logic [6:0]       seg_units_n
);
    localparam int unsigned N_DIGITS = 2;

    logic [3:0] digit_code [N_DIGITS];
    seg_t       digit_seg  [N_DIGITS];

    park_popcount #(.WIDTH(SLOTS), .CNT_W(CNT_W)) count_i (
        .bits_in  (slot_occ),
        .ones_out (occ_cnt)
    );

    park_free_calc #(.CAPACITY(SLOTS), .CNT_W(CNT_W), .RS_W(RS_W)) calc_i (
        .occ_in   (occ_cnt),
        .resv_in  (resv_cnt),
        .free_out (free_cnt),
        .full_out (full)
    );

    park_bcd_split #(.CNT_W(CNT_W)) bcd_i (
        .bin_in    (free_cnt),
        .tens_out  (tens_bcd),
        .units_out (units_bcd)
    );

    assign digit_code[0] = units_bcd;
    assign digit_code[1] = tens_bcd;

    for (genvar g = 0; g < N_DIGITS; g++) begin : g_digit
        park_seg7 seg_i (
            .code_in   (digit_code[g]),
            .seg_n_out (digit_seg[g])
        );
    end

    assign seg_units_n = digit_seg[0];
    assign seg_tens_n  = digit_seg[1];
endmodule

module park_free_display_chk #(
    parameter int unsigned SLOTS = 31,
    parameter int unsigned RS_W  = 5,
    parameter int unsigned CNT_W = 5
) (
    input logic [SLOTS-1:0] slot_occ,
    input logic [RS_W-1:0]  resv_cnt,
    input logic [CNT_W-1:0] occ_cnt,
    input logic [CNT_W-1:0] free_cnt,
    input logic             full,
    input logic [3:0]       tens_bcd,
    input logic [3:0]       units_bcd,
    input logic [6:0]       seg_tens_n,
    input logic [6:0]       seg_units_n
);
    int unsigned used_sum;
    int unsigned digit_sum;

    always_comb begin
        used_sum  = int'(occ_cnt) + int'(resv_cnt);
        digit_sum = int'(tens_bcd) * 10 + int'(units_bcd);
        // R1
        ones_match_chk: assert (int'(occ_cnt) == $countones(slot_occ));
        // R3
        full_flag_chk: assert (full == (used_sum >= SLOTS));
        // R2
        free_sum_chk: assert (full || (used_sum + int'(free_cnt) == SLOTS));
        // R4
        full_clamp_chk: assert (!full || (free_cnt == '0 && tens_bcd == 4'd0 && units_bcd == 4'd0));
        // R5
        bcd_rebuild_chk: assert (units_bcd <= 4'd9 && digit_sum == int'(free_cnt));
        // R6
        seg_lit_chk: assert (seg_units_n != 7'h7F && seg_tens_n != 7'h7F);
    end
endmodule

bind park_free_display park_free_display_chk #(.SLOTS(SLOTS), .RS_W(RS_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/park_free_display_tb_top.sv
module park_free_display_tb_top;
    localparam int SLOTS = 31;

    logic        clk = 1'b0;
    logic [30:0] slot_occ;
    logic [4:0]  resv_cnt;
    logic [4:0]  occ_cnt, free_cnt;
    logic        full;
    logic [3:0]  tens_bcd, units_bcd;
    logic [6:0]  seg_tens_n, seg_units_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    park_free_display dut_i (
        .slot_occ    (slot_occ),
        .resv_cnt    (resv_cnt),
        .occ_cnt     (occ_cnt),
        .free_cnt    (free_cnt),
        .full        (full),
        .tens_bcd    (tens_bcd),
        .units_bcd   (units_bcd),
        .seg_tens_n  (seg_tens_n),
        .seg_units_n (seg_units_n)
    );

    function automatic logic [6:0] ref_seg(input int d);
        logic [6:0] on;
        case (d)
            0: on = 7'b0111111;
            1: on = 7'b0000110;
            2: on = 7'b1011011;
            3: on = 7'b1001111;
            4: on = 7'b1100110;
            5: on = 7'b1101101;
            6: on = 7'b1111101;
            7: on = 7'b0000111;
            8: on = 7'b1111111;
            9: on = 7'b1101111;
            default: on = 7'b0000000;
        endcase
        return ~on;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (D=%h RS=%0d)", req, act, exp, slot_occ, resv_cnt);
        end
    endtask

    task automatic apply_and_check(input logic [30:0] d, input int rs, input int ones);
        int diff, fs;
        @(negedge clk);
        slot_occ = d;
        resv_cnt = 5'(rs);
        @(posedge clk);
        #2;
        diff = SLOTS - ones - rs;
        fs   = (diff > 0) ? diff : 0;
        chk("R1 occupied count", int'(occ_cnt), ones);
        chk("R2 free count", int'(free_cnt), fs);
        chk("R3 full flag", int'(full), (diff <= 0) ? 1 : 0);
        if (diff <= 0) begin
            chk("R4 tens zero when full", int'(tens_bcd), 0);
            chk("R4 units zero when full", int'(units_bcd), 0);
        end
        chk("R5 tens digit", int'(tens_bcd), fs / 10);
        chk("R5 units digit", int'(units_bcd), fs % 10);
        chk("R6 tens segments", int'(seg_tens_n), int'(ref_seg(fs / 10)));
        chk("R6 units segments", int'(seg_units_n), int'(ref_seg(fs % 10)));
    endtask

    function automatic logic [30:0] make_vec(input int n, input int k);
        logic [30:0] v = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (((i + k) % SLOTS) < n) v[i] = 1'b1;
        end
        return v;
    endfunction

    initial begin
        #150000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        slot_occ = '0;
        resv_cnt = '0;
        // initial state: empty garage, no reservations -> 31 free
        apply_and_check('0, 0, 0);
        // R1 stated example vector: 21 occupied
        apply_and_check(31'b100_1011_1110_1111_1000_1111_1010_1110, 5, 21);
        // R5 value 13 -> tens 1, units 3
        apply_and_check(make_vec(13, 4), 5, 13);
        // all ones: full (R3)
        apply_and_check('1, 0, 31);
        // exact boundary occ+rs = 31 (R3, R4)
        apply_and_check(make_vec(16, 9), 15, 16);
        // over-reserved (R3, R4)
        apply_and_check(make_vec(28, 2), 16, 28);
        // full sweep of occupied count versus reserved count
        for (int n = 0; n <= SLOTS; n++) begin
            for (int rs = 0; rs < 32; rs++) begin
                apply_and_check(make_vec(n, (rs * 7 + n) % SLOTS), rs, n);
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule